// File: doc/BRIEF.md
# Delay-Line Code Density Calibrator

This block calibrates the fine stage of a tapped-delay-line time-to-digital converter. Hits that arrive at random, with no correlation to the clock, are converted to fine codes. The block counts how often each code occurs, with one counter per delay tap held in an on-chip RAM. A wide delay cell catches proportionally more hits, so each counter measures the width of its tap.

A start pulse first zeroes every counter and then opens a collection window. The window closes after a fixed number of accepted hits. A single pass over the bins then derives three values per tap. The first is the differential nonlinearity (DNL), relative to the ideal count. The second is the integral nonlinearity (INL), the running sum of DNL. The third is a calibrated time for the centre of the bin, in ideal LSBs. These values feed a per-tap correction. Once the done flag is high, a host reads every bin through a registered read port.

Top module: `cdh_calibrator`

## Requirements
- R1: After reset is released, done is low. Hits presented before any start pulse do not open a collection window, and done stays low.
- R2: A start pulse seen in the idle or done state drives done low on the next cycle. The 2^CODE_W counters are then zeroed over 2^CODE_W cycles, and hits presented during the zeroing are not counted.
- R3: During collection, hit_valid high at a rising edge adds one to the counter addressed by hit_code. Hits to the same code on consecutive cycles are all counted.
- R4: Collection accepts exactly SAMPLES hits. Valid hits after that are ignored.
- R5: done rises no later than 2^CODE_W+6 cycles after the edge that takes the final hit. It then stays high until the next start pulse.
- R6: rd_addr is sampled at a rising edge. The count, DNL, INL and midpoint for that bin appear on the outputs in the following cycle and are valid while done is high.
- R7: rd_dnl is two's complement with FRAC_W fraction bits. Its value is (count − ideal)·2^FRAC_W / ideal, truncated toward zero, where ideal = floor(SAMPLES / 2^CODE_W).
- R8: rd_inl for bin i is the signed sum of the DNL values of bins 0 through i, with FRAC_W fraction bits.
- R9: rd_mid for bin i is floor((2·S + count_i)·2^(FRAC_W−1) / ideal), unsigned with FRAC_W fraction bits, where S is the sum of the counts of bins 0 through i−1.
- R10: Hits presented while done is high leave every counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Pulse: clear the histogram and begin a new collection |
| hit_valid | input | 1 | A fine code is present this cycle |
| hit_code | input | CODE_W | Fine code (delay tap index) of the hit |
| rd_addr | input | CODE_W | Bin to read |
| rd_count | output | clog2(SAMPLES+1) | Hit count of the addressed bin |
| rd_dnl | output | clog2(SAMPLES+1)+FRAC_W+2 | Signed DNL of the addressed bin |
| rd_inl | output | clog2(SAMPLES+1)+FRAC_W+CODE_W+2 | Signed INL up to and including the addressed bin |
| rd_mid | output | clog2(SAMPLES+1)+FRAC_W+1 | Calibrated bin midpoint in ideal LSBs |
| done | output | 1 | Collection and processing finished, results readable |

## Verification
Each hit is presented between edges and counts as taken at the following rising edge. The reference model therefore counts a hit in the same cycle it is driven, and only while its own phase says the window is open. Because of a read-modify-write step and the bin sweep, done follows the final accepted hit by 2^CODE_W+4 cycles. On every clock the bench checks that done is low while hits are still due and high once it has risen, and it allows the rise anywhere up to the R5 bound. A read address is applied after one edge and takes effect at the next. The result is sampled at the falling edge that follows that next edge, which matches the one-cycle latency of R6.

// File: rtl/cdh_pkg.sv
package cdh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_RUN   = 3'd2,
    ST_PROC  = 3'd3,
    ST_DONE  = 3'd4
  } cdh_state_e;

endpackage

// File: rtl/cdh_ram.sv
module cdh_ram #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // one write port, one registered read port (read returns the old word)
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cdh_bin_math.sv
module cdh_bin_math #(
  parameter int CNT_W  = 14,
  parameter int FRAC_W = 8,
  parameter int IDEAL  = 625
) (
  input  logic        [CNT_W-1:0]        cnt,
  input  logic        [CNT_W-1:0]        cum,
  output logic signed [CNT_W+FRAC_W+1:0] dnl,
  output logic        [CNT_W+FRAC_W:0]   mid
);
  localparam int SW = CNT_W + FRAC_W + 2;
  localparam int MW = CNT_W + FRAC_W + 1;

  logic signed [SW-1:0] diff;
  logic signed [SW-1:0] scaled;
  logic        [MW-1:0] num;

  always_comb begin
    diff   = $signed(SW'(cnt)) - $signed(SW'(IDEAL));
    scaled = diff <<< FRAC_W;
    dnl    = scaled / $signed(SW'(IDEAL));
    num    = ((MW'(cum) << 1) + MW'(cnt)) << (FRAC_W - 1);
    mid    = num / MW'(IDEAL);
  end
endmodule

// File: rtl/cdh_calibrator.sv
module cdh_calibrator
  import cdh_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int SAMPLES = 10000,
  parameter int FRAC_W  = 8
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          start,
  input  logic                                          hit_valid,
  input  logic [CODE_W-1:0]                             hit_code,
  input  logic [CODE_W-1:0]                             rd_addr,
  output logic [$clog2(SAMPLES+1)-1:0]                  rd_count,
  output logic [$clog2(SAMPLES+1)+FRAC_W+1:0]           rd_dnl,
  output logic [$clog2(SAMPLES+1)+FRAC_W+CODE_W+1:0]    rd_inl,
  output logic [$clog2(SAMPLES+1)+FRAC_W:0]             rd_mid,
  output logic                                          done
);
  localparam int BINS  = 1 << CODE_W;
  localparam int IDEAL = SAMPLES / BINS;
  localparam int CNT_W = $clog2(SAMPLES + 1);
  localparam int DNL_W = CNT_W + FRAC_W + 2;
  localparam int INL_W = DNL_W + CODE_W;
  localparam int MID_W = CNT_W + FRAC_W + 1;
  localparam int RES_W = DNL_W + INL_W + MID_W;
  localparam int PTR_W = CODE_W + 1;
  localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(BINS);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(BINS - 1);
  localparam logic [CNT_W-1:0] CAP      = CNT_W'(SAMPLES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  cdh_state_e                state_q, state_d;
  logic [PTR_W-1:0]          ptr_q, ptr_d;
  logic [CNT_W-1:0]          accepted_q, accepted_d;
  logic                      s1_v_q, s1_v_d;
  logic [CODE_W-1:0]         s1_addr_q, s1_addr_d;
  logic                      wq_v_q, wq_v_d;
  logic [CODE_W-1:0]         wq_addr_q, wq_addr_d;
  logic [CNT_W-1:0]          wq_data_q, wq_data_d;
  logic                      pv_q, pv_d;
  logic [CODE_W-1:0]         pa_q, pa_d;
  logic [CNT_W-1:0]          cum_q, cum_d;
  logic signed [INL_W-1:0]   inl_q, inl_d;

  // histogram RAM signals
  logic                      cnt_we;
  logic [CODE_W-1:0]         cnt_waddr, cnt_raddr;
  logic [CNT_W-1:0]          cnt_wdata, cnt_rdata;
  logic                      hit_take;
  logic [CNT_W-1:0]          rmw_old, rmw_new;

  // result RAM signals
  logic                      res_we;
  logic [RES_W-1:0]          res_wdata, res_rdata;
  logic signed [DNL_W-1:0]   bin_dnl;
  logic [MID_W-1:0]          bin_mid;
  logic signed [INL_W-1:0]   inl_next;

  cdh_ram #(.AW(CODE_W), .DW(CNT_W)) u_hist (
    .clk  (clk),
    .we   (cnt_we),
    .waddr(cnt_waddr),
    .wdata(cnt_wdata),
    .raddr(cnt_raddr),
    .rdata(cnt_rdata)
  );

  cdh_ram #(.AW(CODE_W), .DW(RES_W)) u_result (
    .clk  (clk),
    .we   (res_we),
    .waddr(pa_q),
    .wdata(res_wdata),
    .raddr(rd_addr),
    .rdata(res_rdata)
  );

  cdh_bin_math #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .IDEAL(IDEAL)) u_math (
    .cnt(cnt_rdata),
    .cum(cum_q),
    .dnl(bin_dnl),
    .mid(bin_mid)
  );

  // read-modify-write with forwarding of the word written one edge earlier
  always_comb begin
    hit_take = (state_q == ST_RUN) && hit_valid && (accepted_q != CAP);
    rmw_old  = (wq_v_q && (wq_addr_q == s1_addr_q)) ? wq_data_q : cnt_rdata;
    rmw_new  = rmw_old + CNT_W'(1);
    inl_next = inl_q + INL_W'(bin_dnl);
    res_wdata = {bin_dnl, inl_next, bin_mid};
  end

  always_comb begin
    unique case (state_q)
      ST_RUN:  cnt_raddr = hit_code;
      ST_PROC: cnt_raddr = ptr_q[CODE_W-1:0];
      default: cnt_raddr = rd_addr;
    endcase
    cnt_we    = 1'b0;
    cnt_waddr = s1_addr_q;
    cnt_wdata = rmw_new;
    if (state_q == ST_CLEAR) begin
      cnt_we    = 1'b1;
      cnt_waddr = ptr_q[CODE_W-1:0];
      cnt_wdata = '0;
    end else if ((state_q == ST_RUN) && s1_v_q) begin
      cnt_we = 1'b1;
    end
    res_we = (state_q == ST_PROC) && pv_q;
  end

  // next state
  always_comb begin
    state_d    = state_q;
    ptr_d      = ptr_q;
    accepted_d = accepted_q;
    s1_v_d     = hit_take;
    s1_addr_d  = hit_code;
    wq_v_d     = (state_q == ST_RUN) && s1_v_q;
    wq_addr_d  = s1_addr_q;
    wq_data_d  = rmw_new;
    pv_d       = 1'b0;
    pa_d       = pa_q;
    cum_d      = cum_q;
    inl_d      = inl_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d = ST_CLEAR;
          ptr_d   = '0;
        end
      end
      ST_CLEAR: begin
        ptr_d = ptr_q + PTR_W'(1);
        if (ptr_q == PTR_LAST) begin
          state_d    = ST_RUN;
          ptr_d      = '0;
          accepted_d = '0;
        end
      end
      ST_RUN: begin
        accepted_d = accepted_q + CNT_W'(hit_take);
        if ((accepted_q == CAP) && !s1_v_q) begin
          state_d = ST_PROC;
          ptr_d   = '0;
          cum_d   = '0;
          inl_d   = '0;
        end
      end
      ST_PROC: begin
        if (ptr_q != PTR_END) begin
          ptr_d = ptr_q + PTR_W'(1);
          pv_d  = 1'b1;
          pa_d  = ptr_q[CODE_W-1:0];
        end
        if (pv_q) begin
          cum_d = cum_q + cnt_rdata;
          inl_d = inl_next;
          if (pa_q == PTR_LAST[CODE_W-1:0]) state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q    <= ST_IDLE;
      ptr_q      <= '0;
      accepted_q <= '0;
      s1_v_q     <= 1'b0;
      s1_addr_q  <= '0;
      wq_v_q     <= 1'b0;
      wq_addr_q  <= '0;
      wq_data_q  <= '0;
      pv_q       <= 1'b0;
      pa_q       <= '0;
      cum_q      <= '0;
      inl_q      <= '0;
    end else begin
      state_q    <= state_d;
      ptr_q      <= ptr_d;
      accepted_q <= accepted_d;
      s1_v_q     <= s1_v_d;
      s1_addr_q  <= s1_addr_d;
      wq_v_q     <= wq_v_d;
      wq_addr_q  <= wq_addr_d;
      wq_data_q  <= wq_data_d;
      pv_q       <= pv_d;
      pa_q       <= pa_d;
      cum_q      <= cum_d;
      inl_q      <= inl_d;
    end
  end

  assign rd_count = cnt_rdata;
  assign rd_dnl   = res_rdata[RES_W-1 -: DNL_W];
  assign rd_inl   = res_rdata[MID_W +: INL_W];
  assign rd_mid   = res_rdata[0 +: MID_W];
  assign done     = (state_q == ST_DONE);
endmodule

// File: rtl/cdh_checker.sv
module cdh_checker
  import cdh_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int SAMPLES = 10000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input cdh_state_e       state,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] accepted
);
  AST_CLEAR_WRITES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CLEAR) |-> (cnt_we && (cnt_wdata == '0)));  // R2
  AST_DONE_FREEZES_HIST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cnt_we);  // R10
  AST_ACCEPT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (32'(accepted) <= SAMPLES));  // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);  // R5
  AST_START_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !done);  // R2
  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RUN) && cnt_we) |-> ((cnt_wdata != '0) && (cnt_wdata <= accepted)));  // R3
endmodule

bind cdh_calibrator cdh_checker #(.CNT_W(CNT_W), .SAMPLES(SAMPLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .start    (start),
  .done     (done),
  .state    (state_q),
  .cnt_we   (cnt_we),
  .cnt_wdata(cnt_wdata),
  .accepted (accepted_q)
);

// File: tb/sim_cdh_calibrator.sv
`timescale 1ns/1ps
module sim_cdh_calibrator;
  localparam int CODE_W  = 4;
  localparam int BINS    = 1 << CODE_W;
  localparam int SAMPLES = 10000;
  localparam int FRAC_W  = 8;
  localparam int IDEAL   = SAMPLES / BINS;
  localparam int CNT_W   = $clog2(SAMPLES + 1);
  localparam int DNL_W   = CNT_W + FRAC_W + 2;
  localparam int INL_W   = DNL_W + CODE_W;
  localparam int MID_W   = CNT_W + FRAC_W + 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic              hit_valid;
  logic [CODE_W-1:0] hit_code;
  logic [CODE_W-1:0] rd_addr;
  logic [CNT_W-1:0]  rd_count;
  logic [DNL_W-1:0]  rd_dnl;
  logic [INL_W-1:0]  rd_inl;
  logic [MID_W-1:0]  rd_mid;
  logic              done;

  always #2.5 clk = ~clk;

  cdh_calibrator #(.CODE_W(CODE_W), .SAMPLES(SAMPLES), .FRAC_W(FRAC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .hit_valid(hit_valid),
    .hit_code(hit_code), .rd_addr(rd_addr), .rd_count(rd_count),
    .rd_dnl(rd_dnl), .rd_inl(rd_inl), .rd_mid(rd_mid), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  int model_cnt [BINS];
  int model_acc = 0;
  int phase = 0;   // 0 idle/clear, 1 collecting, 2 final taken, 3 done, 4 late
  int since = 0;
  int cyc = 0;
  bit finished = 0;
  int unsigned lcg = 32'd12345;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(bit v, int c);
    @(posedge clk); #1;
    hit_valid = v;
    hit_code  = CODE_W'(c);
  endtask

  // behavioural model of acceptance and the done timing, every clock
  always @(negedge clk) begin
    if (phase == 1) begin
      check(done == 1'b0, "R5", "done while collecting", done, 0);
      if (hit_valid) begin
        model_cnt[hit_code]++;
        model_acc++;
        if (model_acc == SAMPLES) begin
          phase = 2;
          since = 0;
        end
      end
    end else if (phase == 2) begin
      since++;
      if (done) begin
        check(since <= BINS + 6, "R5", "done latency", since, BINS + 6);
        phase = 3;
      end else if (since > BINS + 6) begin
        check(1'b0, "R5", "done latency", since, BINS + 6);
        phase = 4;
      end
    end else if (phase == 3) begin
      check(done == 1'b1, "R5", "done held", done, 1);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic int next_rand();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'(lcg >> 8);
  endfunction

  task automatic pulse_start();
    @(posedge clk); #1;
    start = 1'b1;
    phase = 0;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R2", "done after start", done, 0);
  endtask

  // variant 0 favours low codes, variant 1 favours high codes
  task automatic collect(int variant);
    for (int b = 0; b < BINS; b++) model_cnt[b] = 0;
    model_acc = 0;
    // hits during zeroing must not count (R2)
    for (int k = 0; k < 6; k++) drive(1, k);
    drive(0, 0);
    repeat (2 * BINS) @(posedge clk);
    phase = 1;
    // burst to one code on consecutive cycles (R3)
    for (int k = 0; k < 40; k++) drive(1, 3 + variant * 9);
    while (phase == 1) begin
      int r = next_rand();
      int c = r % BINS;
      bit v = ((r >> 10) % 4) != 0;
      if (((r >> 4) & 1) == 1) begin
        if (variant == 0) c = c % (BINS / 2);
        else              c = BINS / 2 + (c % (BINS / 2));
      end
      if ((r % 97) == 0) begin
        for (int k = 0; k < 5; k++) if (phase == 1) drive(1, c);
      end else begin
        drive(v, c);
      end
    end
    // beyond the sample count: ignored (R4)
    for (int k = 0; k < 30; k++) drive(1, k % BINS);
    drive(0, 0);
    while (phase < 3) @(posedge clk);
  endtask

  task automatic read_bin(int b);
    @(posedge clk); #1;
    rd_addr = CODE_W'(b);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_results(string tag);
    int cum = 0;
    int inl = 0;
    int total = 0;
    for (int b = 0; b < BINS; b++) begin
      int dnl_e = ((model_cnt[b] - IDEAL) * (1 << FRAC_W)) / IDEAL;
      int mid_e = ((2 * cum + model_cnt[b]) * (1 << (FRAC_W - 1))) / IDEAL;
      inl += dnl_e;
      read_bin(b);
      check(int'(rd_count) == model_cnt[b], "R3", {tag, " bin count"}, rd_count, model_cnt[b]);
      check(longint'($signed(rd_dnl)) == dnl_e, "R7", {tag, " dnl"}, $signed(rd_dnl), dnl_e);
      check(longint'($signed(rd_inl)) == inl, "R8", {tag, " inl"}, $signed(rd_inl), inl);
      check(int'(rd_mid) == mid_e, "R9", {tag, " midpoint"}, rd_mid, mid_e);
      cum += model_cnt[b];
      total += int'(rd_count);
    end
    check(total == SAMPLES, "R4", {tag, " total hits"}, total, SAMPLES);
    // R6: back-to-back reads of two different bins, one cycle each
    read_bin(0);
    check(int'(rd_count) == model_cnt[0], "R6", "read latency bin0", rd_count, model_cnt[0]);
    read_bin(BINS - 1);
    check(int'(rd_count) == model_cnt[BINS-1], "R6", "read latency last bin", rd_count, model_cnt[BINS-1]);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    hit_valid = 1'b0;
    hit_code = '0;
    rd_addr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    // hits in idle do not start anything (R1)
    for (int k = 0; k < 20; k++) drive(1, k % BINS);
    drive(0, 0);
    repeat (BINS + 10) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R1", "done after idle hits", done, 0);

    pulse_start();
    collect(0);
    check_results("run1");

    // hits while done leave the histogram untouched (R10)
    for (int k = 0; k < 40; k++) drive(1, (k * 7) % BINS);
    drive(0, 0);
    for (int b = 0; b < BINS; b++) begin
      read_bin(b);
      check(int'(rd_count) == model_cnt[b], "R10", "count after done hits", rd_count, model_cnt[b]);
    end

    lcg = 32'd987654321;
    pulse_start();
    collect(1);
    check_results("run2");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule